// File: doc/BRIEF.md
# Programmable 64-Input Interrupt Controller

The controller watches up to 64 external interrupt lines and turns each pending, unmasked and message-enabled line into a vector message on a valid/ready output. Every line is resynchronised by two flops and can be configured as rising-edge, falling-edge, active-high level or active-low level. Edge lines set a pending latch that software can clear; level lines stay pending for as long as the input is active.

Configuration sits behind a 32-bit register port that is addressed by word index (byte offset divided by four). Writes take effect on the clock edge. Reads are combinational and have no side effects, so software can save the configuration and later restore it. Each line owns an 8-bit vector byte and an 8-bit route byte, and both bytes travel with its message.

A two-state arbiter drives the output. In `ARB_SCAN` it picks the lowest-numbered eligible line and captures that line's number, vector and route. It then moves to `ARB_OFFER` if any line is eligible, and otherwise stays in `ARB_SCAN`. In `ARB_OFFER` it holds `msg_valid` high with stable fields. It returns to `ARB_SCAN` when `msg_ready` is seen high, which is the handshake, and otherwise stays in `ARB_OFFER`.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset the mask words read all ones, and the edge, polarity, message-enable, bounce, vector and route storage read zero. `msg_valid` is low.
- R2: Each grouped register has two words, covering lines 0-31 and lines 32-63, and line N uses bit N%32 of word N/32. The byte offsets are: mask 0x20, message-enable 0x40, edge-select 0x60, clear 0x80, bounce 0xC0 and 0xE0, polarity 0x3E0. The route byte of line N is at 0x100+N and its vector byte is at 0x200+N, in byte lane N%4 of the word at byte offset (base + N) with the low two bits cleared. Every stored word reads back what was written, and the clear words read zero.
- R3: Bits 23:16 of the word at byte offset 0x4, which are bits 55:48 of the 64-bit identity value, read the number of lines minus one, which is 63. The word at offset 0x0 reads zero.
- R4: The trigger type of a line is set by its edge and polarity bits: edge 1 with polarity 0 is a rising edge, edge 1 with polarity 1 is a falling edge, edge 0 with polarity 0 is level high, and edge 0 with polarity 1 is level low.
- R5: A detected edge sets the line's pending latch. Writing 1 to the line's clear bit empties the latch, and clear bits written as 0 leave latches unchanged.
- R6: Level lines are never latched. They are pending exactly while the polarity-adjusted input is active, and clear writes have no effect on them.
- R7: A mask bit of 1 blocks the line's message but keeps its latched edge. Setting the mask bit back to 0 releases the message.
- R8: A line with its message-enable bit at 0 emits nothing. Its latched edge is emitted once the bit is set.
- R9: When several lines are eligible, the lowest-numbered line is emitted first.
- R10: While `msg_valid` is high and `msg_ready` is low, the valid signal, vector, route and line stay unchanged. Acceptance of an edge line's message clears its latch, so it is emitted once per edge. A level line that is still active is emitted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_word | input | 8 | Register word index (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_word` |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with `msg_valid` |
| msg_vector | output | 8 | Vector byte of the offered line |
| msg_route | output | 8 | Route byte of the offered line |
| msg_line | output | 6 | Number of the offered line |

## Verification
The assertions assume that `irq_in` pulses last at least two clock cycles, so that the synchroniser always captures them. They also assume that a change of polarity on an edge line, which can look like an edge, is followed by a clear write before the line is unmasked. The stimulus holds each random pulse for three cycles and makes every polarity or type change while the line is masked, then clears it. Random mask patterns and a randomly toggled `msg_ready` exercise the arbiter's hold and priority rules without breaking these assumptions.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int VEC_W  = 8;
    localparam int WORD_W = 32;

    typedef enum logic {
        ARB_SCAN,
        ARB_OFFER
    } arb_state_t;

    // Word indices (byte offset >> 2) of the register map
    localparam logic [7:0] IDX_ID_LO = 8'h00;
    localparam logic [7:0] IDX_ID_HI = 8'h01;
    localparam logic [7:0] IDX_MASK  = 8'h08;
    localparam logic [7:0] IDX_MSGEN = 8'h10;
    localparam logic [7:0] IDX_EDGE  = 8'h18;
    localparam logic [7:0] IDX_CLR   = 8'h20;
    localparam logic [7:0] IDX_BNC0  = 8'h30;
    localparam logic [7:0] IDX_BNC1  = 8'h38;
    localparam logic [7:0] IDX_ROUTE = 8'h40;
    localparam logic [7:0] IDX_VEC   = 8'h80;
    localparam logic [7:0] IDX_POL   = 8'hF8;
endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
#(
    parameter int NLINES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [7:0]              widx,
    input  logic [WORD_W-1:0]       wdata,
    output logic [WORD_W-1:0]       rdata,
    output logic [NLINES-1:0]       mask_o,
    output logic [NLINES-1:0]       msgen_o,
    output logic [NLINES-1:0]       edge_o,
    output logic [NLINES-1:0]       pol_o,
    output logic [NLINES-1:0]       clr_o,
    output logic [NLINES*VEC_W-1:0] vec_o,
    output logic [NLINES*VEC_W-1:0] route_o
);
    localparam int NWORDS = NLINES / WORD_W;
    localparam int NBYTEW = NLINES * VEC_W / WORD_W;

    logic [NLINES-1:0]       mask_q, msgen_q, edge_q, pol_q, bnc0_q, bnc1_q;
    logic [NLINES*VEC_W-1:0] vec_q, route_q;

    function automatic logic hit(input logic [7:0] idx, input logic [7:0] base, input int off);
        return idx == 8'(int'(base) + off);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            msgen_q <= '0;
            edge_q  <= '0;
            pol_q   <= '0;
            bnc0_q  <= '0;
            bnc1_q  <= '0;
            vec_q   <= '0;
            route_q <= '0;
        end else if (wr_en) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (hit(widx, IDX_MASK,  w)) mask_q [w*WORD_W +: WORD_W] <= wdata;
                if (hit(widx, IDX_MSGEN, w)) msgen_q[w*WORD_W +: WORD_W] <= wdata;
                if (hit(widx, IDX_EDGE,  w)) edge_q [w*WORD_W +: WORD_W] <= wdata;
                if (hit(widx, IDX_POL,   w)) pol_q  [w*WORD_W +: WORD_W] <= wdata;
                if (hit(widx, IDX_BNC0,  w)) bnc0_q [w*WORD_W +: WORD_W] <= wdata;
                if (hit(widx, IDX_BNC1,  w)) bnc1_q [w*WORD_W +: WORD_W] <= wdata;
            end
            for (int k = 0; k < NBYTEW; k++) begin
                if (hit(widx, IDX_ROUTE, k)) route_q[k*WORD_W +: WORD_W] <= wdata;
                if (hit(widx, IDX_VEC,   k)) vec_q  [k*WORD_W +: WORD_W] <= wdata;
            end
        end
    end

    // Write-one-to-clear pulses, one cycle wide
    always_comb begin
        clr_o = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (wr_en && hit(widx, IDX_CLR, w)) clr_o[w*WORD_W +: WORD_W] = wdata;
        end
    end

    // Side-effect-free read mux
    always_comb begin
        rdata = '0;
        if (widx == IDX_ID_HI) rdata[23:16] = 8'(NLINES - 1);
        for (int w = 0; w < NWORDS; w++) begin
            if (hit(widx, IDX_MASK,  w)) rdata = mask_q [w*WORD_W +: WORD_W];
            if (hit(widx, IDX_MSGEN, w)) rdata = msgen_q[w*WORD_W +: WORD_W];
            if (hit(widx, IDX_EDGE,  w)) rdata = edge_q [w*WORD_W +: WORD_W];
            if (hit(widx, IDX_POL,   w)) rdata = pol_q  [w*WORD_W +: WORD_W];
            if (hit(widx, IDX_BNC0,  w)) rdata = bnc0_q [w*WORD_W +: WORD_W];
            if (hit(widx, IDX_BNC1,  w)) rdata = bnc1_q [w*WORD_W +: WORD_W];
        end
        for (int k = 0; k < NBYTEW; k++) begin
            if (hit(widx, IDX_ROUTE, k)) rdata = route_q[k*WORD_W +: WORD_W];
            if (hit(widx, IDX_VEC,   k)) rdata = vec_q  [k*WORD_W +: WORD_W];
        end
    end

    assign mask_o  = mask_q;
    assign msgen_o = msgen_q;
    assign edge_o  = edge_q;
    assign pol_o   = pol_q;
    assign vec_o   = vec_q;
    assign route_o = route_q;
endmodule

// File: rtl/irq_line.sv
module irq_line (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_raw,
    input  logic edge_sel,
    input  logic pol,
    input  logic clr,
    input  logic ack,
    output logic pending
);
    logic s1_q, s2_q, prev_q, latch_q;
    logic adj, edge_hit;

    assign adj      = s2_q ^ pol;
    assign edge_hit = adj & ~prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            s1_q    <= irq_raw;
            s2_q    <= s1_q;
            prev_q  <= adj;
            latch_q <= edge_sel & ((latch_q & ~clr & ~ack) | edge_hit);
        end
    end

    assign pending = edge_sel ? latch_q : adj;

    // R5
    clr_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !edge_hit) |=> !latch_q);

    // R6
    lvl_nolatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_sel |=> !latch_q);
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
#(
    parameter int NLINES = 64,
    localparam int LW    = $clog2(NLINES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NLINES-1:0]       eligible,
    input  logic [NLINES*VEC_W-1:0] vec_flat,
    input  logic [NLINES*VEC_W-1:0] route_flat,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic [VEC_W-1:0]        out_vector,
    output logic [VEC_W-1:0]        out_route,
    output logic [LW-1:0]           out_line,
    output logic [NLINES-1:0]       ack
);
    arb_state_t       state_q, state_d;
    logic             found;
    logic [LW-1:0]    pick, line_q;
    logic [VEC_W-1:0] vec_q, route_q;

    // Lowest-numbered eligible line wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found = 1'b1;
                pick  = LW'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_SCAN:  if (found)     state_d = ARB_OFFER;
            ARB_OFFER: if (out_ready) state_d = ARB_SCAN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_SCAN;
            line_q  <= '0;
            vec_q   <= '0;
            route_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_SCAN && found) begin
                line_q  <= pick;
                vec_q   <= vec_flat  [pick*VEC_W +: VEC_W];
                route_q <= route_flat[pick*VEC_W +: VEC_W];
            end
        end
    end

    always_comb begin
        out_valid  = (state_q == ARB_OFFER);
        out_vector = vec_q;
        out_route  = route_q;
        out_line   = line_q;
        ack        = '0;
        if (out_valid && out_ready) ack[line_q] = 1'b1;
    end

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_vector)
                                       && $stable(out_route) && $stable(out_line)));
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
    import irq_pkg::*;
#(
    parameter int NLINES = 64,
    localparam int LW    = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] irq_in,
    input  logic              reg_wr,
    input  logic [7:0]        reg_word,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [VEC_W-1:0]  msg_vector,
    output logic [VEC_W-1:0]  msg_route,
    output logic [LW-1:0]     msg_line
);
    logic [NLINES-1:0]       cfg_mask, cfg_msgen, cfg_edge, cfg_pol, clr_pulse;
    logic [NLINES-1:0]       pending, eligible, ack;
    logic [NLINES*VEC_W-1:0] vec_flat, route_flat;

    irq_regs #(.NLINES(NLINES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .widx    (reg_word),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .mask_o  (cfg_mask),
        .msgen_o (cfg_msgen),
        .edge_o  (cfg_edge),
        .pol_o   (cfg_pol),
        .clr_o   (clr_pulse),
        .vec_o   (vec_flat),
        .route_o (route_flat)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        irq_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_raw  (irq_in[g]),
            .edge_sel (cfg_edge[g]),
            .pol      (cfg_pol[g]),
            .clr      (clr_pulse[g]),
            .ack      (ack[g]),
            .pending  (pending[g])
        );
    end

    assign eligible = pending & ~cfg_mask & cfg_msgen;

    irq_arb #(.NLINES(NLINES)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .eligible   (eligible),
        .vec_flat   (vec_flat),
        .route_flat (route_flat),
        .out_ready  (msg_ready),
        .out_valid  (msg_valid),
        .out_vector (msg_vector),
        .out_route  (msg_route),
        .out_line   (msg_line),
        .ack        (ack)
    );

    logic [NLINES-1:0] below_line;
    assign below_line = (NLINES'(1) << msg_line) - NLINES'(1);

    // R7 R8
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (((($past(cfg_mask) >> msg_line) & NLINES'(1)) == '0)
                           && ((($past(cfg_msgen) >> msg_line) & NLINES'(1)) != '0)));

    // R9
    prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msg_valid) |-> (($past(eligible) & below_line) == '0));
endmodule

// File: tb/test_irq_msg_ctrl.sv
module test_irq_msg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] irq_in;
    logic        reg_wr;
    logic [7:0]  reg_word;
    logic [31:0] reg_wdata, reg_rdata;
    logic        msg_valid, msg_ready;
    logic [7:0]  msg_vector, msg_route;
    logic [5:0]  msg_line;

    always #10 clk = ~clk;

    irq_msg_ctrl i_irq_msg_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_route(msg_route),
        .msg_line(msg_line)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int gl[256];
    logic [7:0] gv[256], gr[256];
    int gcnt;
    logic [31:0] rv;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] vexp(input int n);
        return 8'(n * 7 + 3);
    endfunction
    function automatic logic [7:0] rexp(input int n);
        return 8'(n) ^ 8'h5A;
    endfunction

    task automatic wr(input int byte_off, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_word = 8'(byte_off >> 2); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int byte_off, output logic [31:0] d);
        @(negedge clk);
        reg_word = 8'(byte_off >> 2);
        #1 d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input int cycles, input bit rnd_ready);
        gcnt = 0;
        repeat (cycles) begin
            @(negedge clk);
            msg_ready = rnd_ready ? 1'($urandom % 2) : 1'b1;
            #1;
            if (msg_valid && msg_ready) begin
                if (gcnt < 256) begin
                    gl[gcnt] = int'(msg_line); gv[gcnt] = msg_vector; gr[gcnt] = msg_route;
                end
                gcnt++;
            end
        end
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic pulse(input logic [63:0] p);
        @(negedge clk);
        irq_in = irq_in | p;
        idle(3);
        irq_in = irq_in & ~p;
    endtask

    task automatic expect_seq(input logic [63:0] exp, input string req);
        int k = 0;
        chk(gcnt == $countones(exp), req, "message count", gcnt, $countones(exp));
        for (int i = 0; i < 64; i++) begin
            if (exp[i]) begin
                if (k < gcnt && k < 256) begin
                    chk(gl[k] == i, req, "line order", gl[k], i);
                    chk(gv[k] == vexp(i), "R2", "vector byte", gv[k], vexp(i));
                    chk(gr[k] == rexp(i), "R2", "route byte", gr[k], rexp(i));
                end
                k++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] p, m;
        logic [31:0] pk;
        void'($urandom(32'd4711));
        rst_n = 1'b0; irq_in = '0; reg_wr = 1'b0; reg_word = '0; reg_wdata = '0; msg_ready = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk(msg_valid == 1'b0, "R1", "valid after reset", msg_valid, 0);
        rd(32'h20, rv); chk(rv == 32'hFFFF_FFFF, "R1", "mask word0", rv, 32'hFFFF_FFFF);
        rd(32'h24, rv); chk(rv == 32'hFFFF_FFFF, "R1", "mask word1", rv, 32'hFFFF_FFFF);
        rd(32'h60, rv); chk(rv == 0, "R1", "edge word0", rv, 0);
        rd(32'h44, rv); chk(rv == 0, "R1", "msgen word1", rv, 0);
        rd(32'h210, rv); chk(rv == 0, "R1", "vector word", rv, 0);

        // R3 identity
        rd(32'h4, rv); chk(rv[23:16] == 8'd63, "R3", "line count field", rv[23:16], 63);
        rd(32'h0, rv); chk(rv == 0, "R3", "identity low word", rv, 0);

        // R2 vector and route bytes, storage words
        for (int k = 0; k < 16; k++) begin
            wr(32'h200 + 4 * k, {vexp(4*k+3), vexp(4*k+2), vexp(4*k+1), vexp(4*k)});
            wr(32'h100 + 4 * k, {rexp(4*k+3), rexp(4*k+2), rexp(4*k+1), rexp(4*k)});
        end
        pk = {vexp(43), vexp(42), vexp(41), vexp(40)};
        rd(32'h228, rv); chk(rv == pk, "R2", "vector word 10", rv, pk);
        pk = {rexp(63), rexp(62), rexp(61), rexp(60)};
        rd(32'h13C, rv); chk(rv == pk, "R2", "route word 15", rv, pk);
        wr(32'hC4, 32'hA5C3_0F96);
        rd(32'hC4, rv); chk(rv == 32'hA5C3_0F96, "R2", "bounce word", rv, 32'hA5C3_0F96);
        rd(32'hC4, rv); chk(rv == 32'hA5C3_0F96, "R2", "bounce reread", rv, 32'hA5C3_0F96);
        rd(32'hE0, rv); chk(rv == 0, "R2", "other bounce word", rv, 0);

        // All lines rising edge, enabled, unmasked
        wr(32'h60, '1); wr(32'h64, '1);
        wr(32'h3E0, '0); wr(32'h3E4, '0);
        wr(32'h40, '1); wr(32'h44, '1);
        wr(32'h80, '1); wr(32'h84, '1);
        rd(32'h80, rv); chk(rv == 0, "R2", "clear reads zero", rv, 0);
        rd(32'h64, rv); chk(rv == 32'hFFFF_FFFF, "R2", "edge readback", rv, 32'hFFFF_FFFF);
        wr(32'h20, '0); wr(32'h24, '0);

        // R9 R7 R5 random rounds
        for (int r = 0; r < 12; r++) begin
            p = {$urandom, $urandom};
            m = (r % 2 == 1) ? {$urandom, $urandom} : 64'h0;
            wr(32'h20, m[31:0]); wr(32'h24, m[63:32]);
            rd(32'h24, rv); chk(rv == m[63:32], "R2", "mask readback", rv, m[63:32]);
            pulse(p);
            drain(300, (r % 3) == 0);
            expect_seq(p & ~m, "R9");
            wr(32'h84, 32'h0);
            wr(32'h80, '1); wr(32'h84, '1);
            wr(32'h20, '0); wr(32'h24, '0);
            drain(20, 0);
            chk(gcnt == 0, "R5", "clear removed masked latches", gcnt, 0);
        end

        // R7 masked latch released by unmask
        wr(32'h20, 32'h8);
        pulse(64'h8);
        drain(30, 0);
        chk(gcnt == 0, "R7", "masked line silent", gcnt, 0);
        wr(32'h20, 32'h0);
        drain(30, 0);
        expect_seq(64'h8, "R7");

        // R5 write of zero bits keeps latch, one bit clears
        wr(32'h20, 32'h400);
        pulse(64'h400);
        wr(32'h80, 32'hFFFF_FBFF);
        wr(32'h20, 32'h0);
        drain(30, 0);
        expect_seq(64'h400, "R5");
        wr(32'h20, 32'h400);
        pulse(64'h400);
        wr(32'h80, 32'h400);
        wr(32'h20, 32'h0);
        drain(30, 0);
        chk(gcnt == 0, "R5", "cleared edge", gcnt, 0);

        // R8 message enable
        wr(32'h40, ~32'h80);
        pulse(64'h80);
        drain(30, 0);
        chk(gcnt == 0, "R8", "disabled line silent", gcnt, 0);
        wr(32'h40, '1);
        drain(30, 0);
        expect_seq(64'h80, "R8");

        // R10 hold while not ready, single emission per edge
        pulse(64'h1000);
        idle(8);
        chk(msg_valid == 1'b1, "R10", "offer present", msg_valid, 1);
        pk = {24'h0, msg_vector};
        idle(5);
        chk(msg_valid == 1'b1 && msg_vector == pk[7:0], "R10", "offer held", msg_vector, pk[7:0]);
        drain(30, 0);
        expect_seq(64'h1000, "R10");

        // R4 falling edge on line 5
        wr(32'h20, 32'h20);
        irq_in[5] = 1'b1;
        idle(4);
        wr(32'h3E0, 32'h20);
        wr(32'h80, 32'h20);
        wr(32'h20, 32'h0);
        drain(20, 0);
        chk(gcnt == 0, "R4", "falling edge idle high", gcnt, 0);
        irq_in[5] = 1'b0;
        drain(20, 0);
        expect_seq(64'h20, "R4");
        irq_in[5] = 1'b1;
        drain(20, 0);
        chk(gcnt == 0, "R4", "rising ignored on falling line", gcnt, 0);

        // R6 level high on line 40
        wr(32'h64, ~32'h100);
        irq_in[40] = 1'b1;
        drain(20, 0);
        chk(gcnt >= 3, "R6", "level repeats", gcnt, 3);
        chk(gl[0] == 40, "R6", "level line", gl[0], 40);
        wr(32'h84, 32'h100);
        drain(20, 0);
        chk(gcnt >= 3, "R6", "clear no effect on level", gcnt, 3);
        irq_in[40] = 1'b0;
        drain(20, 0);
        drain(20, 0);
        chk(gcnt == 0, "R6", "level stops when inactive", gcnt, 0);

        // R4 level low on line 63
        wr(32'h24, 32'h8000_0000);
        wr(32'h64, ~32'h8000_0100);
        wr(32'h3E4, 32'h8000_0000);
        wr(32'h24, 32'h0);
        drain(20, 0);
        chk(gcnt >= 3 && gl[0] == 63, "R4", "level low active", gl[0], 63);
        chk(gv[0] == vexp(63), "R4", "level low vector", gv[0], vexp(63));
        irq_in[63] = 1'b1;
        drain(20, 0);
        drain(20, 0);
        chk(gcnt == 0, "R4", "level low inactive", gcnt, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule